// File: doc/BRIEF.md
# Table-lookup Taylor-series significand divider

This block divides two floating-point numbers in a pipeline that takes a new operand pair on every clock. An operand word is laid out as {sign, biased exponent[EW], fraction[2M-1]}. The hidden leading one is restored, so each significand is a 2M-bit fixed-point value in [1,2). The divisor significand Y is split into its top M bits Yh and the remaining M bits Yl. The quotient significand is approximated as X·(Yh − Yl)·(1/Yh²). This is the first-order Taylor expansion of X/Y. It needs one small table of 1/Yh² values, computed at elaboration, and two multipliers. Intermediate products are carried at 2M+2 bits.

A request is presented with `ready` high, and the result appears with `done` high a fixed three cycles later. The result exponent is e_a − e_b + bias. When the quotient significand lands below one, it is shifted left once and the exponent is decremented. An exponent field of zero means the value zero, since denormals are not supported. An incoming exception flag travels with its operands. It is merged with divide-by-zero and exponent-range errors into `exc_out`.

Top module: `sig_taylor_div`

## Requirements
- R1: For non-exceptional, nonzero operands, the result value is within a relative error of 4·2^-(2M-1) of the exact quotient a/b.
- R2: The result sign bit (bit FW-1) equals the XOR of the two operand sign bits, for every result.
- R3: The result exponent field is e_a − e_b + (2^(EW-1) − 1), decreased by one when the quotient significand is below one. The result fraction holds the bits below the leading one.
- R4: `done` is high for exactly one cycle, three clock edges after each cycle in which `ready` was sampled high. Requests may arrive on consecutive cycles, and no `done` appears without a request.
- R5: When `exc_in` is high with a request, `exc_out` is high with that request's result.
- R6: A divisor whose exponent field (bits FW-2 down to 2M-1) is zero raises `exc_out`.
- R7: A dividend whose exponent field is zero, divided by a nonzero divisor, gives a result whose bits below the sign are all zero. It raises no exception of its own.
- R8: For a nonzero dividend, a result exponent below 1 or above 2^EW − 2 raises `exc_out`.
- R9: While and just after `rst_n` is low, `done` and `exc_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ready | input | 1 | Request strobe; operands valid this cycle |
| exc_in | input | 1 | Exception carried in with the operands |
| a | input | EW+2M | Dividend {sign, exponent, fraction} |
| b | input | EW+2M | Divisor {sign, exponent, fraction} |
| done | output | 1 | Result valid strobe |
| exc_out | output | 1 | Exception flag for the current result |
| q | output | EW+2M | Quotient {sign, exponent, fraction} |

## Verification
The bench tests the extreme significand pairs where the approximation is weakest: the largest divisor low half, and a quotient that lands just above one half. A design that mishandled the normalize shift there would report a value twice or half the true one. Equal significands put the quotient on the normalize boundary, where a wrong exponent decrement shows as a factor-of-two error. Exponent overflow and underflow, a zero divisor, a zero dividend and a forwarded exception are all tested, so a dropped or misrouted flag is caught. Streams with irregular gaps in `ready` expose a wrong latency or a lost or spurious `done`.

// File: rtl/sig_taylor_div.sv
module sig_taylor_div #(
  parameter int M  = 8,
  parameter int EW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ready,
  input  logic              exc_in,
  input  logic [EW+2*M-1:0] a,
  input  logic [EW+2*M-1:0] b,
  output logic              done,
  output logic              exc_out,
  output logic [EW+2*M-1:0] q
);
  localparam int SW   = 2 * M;
  localparam int F    = SW - 1;
  localparam int FW   = EW + SW;
  localparam int TW   = SW + 2;
  localparam int NT   = 2 ** (M - 1);
  localparam int XW   = EW + 2;
  localparam int BIAS = 2 ** (EW - 1) - 1;
  localparam logic signed [XW-1:0] EMIN = XW'(1);
  localparam logic signed [XW-1:0] EMAX = XW'(2 ** EW - 2);

  function automatic logic [TW-1:0] recip_sq(int i);
    logic [63:0] n, d;
    n = 64'd1 << (4 * M - 1);
    d = 64'(NT + i) * 64'(NT + i);
    return TW'((n + (d >> 1)) / d);
  endfunction

  logic [TW-1:0] tbl [NT];
  for (genvar i = 0; i < NT; i++) begin : g_tbl
    assign tbl[i] = recip_sq(i);
  end

  wire [SW-1:0] xs = {1'b1, a[F-1:0]};
  wire [SW-1:0] ys = {1'b1, b[F-1:0]};
  wire [EW-1:0] ea = a[FW-2 -: EW];
  wire [EW-1:0] eb = b[FW-2 -: EW];

  wire [SW:0]   dh = {1'b0, ys[SW-1:M], {M{1'b0}}} - {{(M+1){1'b0}}, ys[M-1:0]};
  wire [2*SW:0] p0 = {{(SW+1){1'b0}}, xs} * {{SW{1'b0}}, dh};

  logic [TW-1:0] p1, t1;
  logic [SW:0]   q2;
  logic          v1, v2, s1, s2, z1, z2, x1, x2;
  logic signed [XW-1:0] e1, e2;

  wire [2*TW-1:0] p2 = {{TW{1'b0}}, p1} * {{TW{1'b0}}, t1};

  always_ff @(posedge clk) begin
    p1 <= p0[4*M-1:2*M-2];
    t1 <= tbl[ys[SW-2:M]];
    s1 <= a[FW-1] ^ b[FW-1];
    z1 <= (ea == '0);
    x1 <= exc_in | (eb == '0);
    e1 <= $signed({2'b00, ea}) - $signed({2'b00, eb}) + XW'(BIAS);
    q2 <= p2[4*M+1:2*M+1];
    s2 <= s1;
    z2 <= z1;
    x2 <= x1;
    e2 <= e1;
  end

  wire dec = !q2[SW];
  wire low = !q2[SW] && !q2[SW-1];
  wire [F-1:0] frac = low ? '0 : (q2[SW] ? q2[SW-1:1] : q2[SW-2:0]);
  wire signed [XW-1:0] ef = e2 - XW'(dec);
  wire rng_bad = (ef < EMIN) || (ef > EMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      done <= 1'b0;
      exc_out <= 1'b0;
      q <= '0;
    end else begin
      v1 <= ready;
      v2 <= v1;
      done <= v2;
      if (v2) begin
        exc_out <= x2 | (!z2 & rng_bad);
        q <= z2 ? {s2, {(FW-1){1'b0}}} : {s2, ef[EW-1:0], frac};
      end
    end
  end
endmodule

module sig_taylor_div_chk #(
  parameter int FW = 24,
  parameter int EW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          exc_in,
  input logic [FW-1:0] a,
  input logic [FW-1:0] b,
  input logic          done,
  input logic          exc_out,
  input logic [FW-1:0] q
);
  assert_done_has_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(ready, 3));

  assert_req_gives_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ##2 done);

  assert_sign_xor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> q[FW-1] == $past(a[FW-1] ^ b[FW-1], 3));

  assert_exc_forward_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(exc_in, 3) |-> exc_out);

  assert_div_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(b[FW-2 -: EW] == '0, 3) |-> exc_out);

  assert_zero_dividend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(a[FW-2 -: EW] == '0 && b[FW-2 -: EW] != '0, 3)
    |-> q[FW-2:0] == '0 && exc_out == $past(exc_in, 3));
endmodule

bind sig_taylor_div sig_taylor_div_chk #(.FW(EW + 2*M), .EW(EW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .exc_in(exc_in), .a(a), .b(b),
  .done(done), .exc_out(exc_out), .q(q)
);

// File: tb/sig_taylor_div_tb.sv
module sig_taylor_div_tb;
  localparam int M = 8;
  localparam int EW = 8;
  localparam int FW = EW + 2 * M;
  localparam int F = 2 * M - 1;
  localparam int BIAS = 2 ** (EW - 1) - 1;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready = 1'b0;
  logic exc_in = 1'b0;
  logic [FW-1:0] a = '0;
  logic [FW-1:0] b = '0;
  wire done, exc_out;
  wire [FW-1:0] q;

  typedef struct {
    logic  sgn;
    logic  exc;
    logic  zero;
    real   val;
    int    due;
    string tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;

  sig_taylor_div #(.M(M), .EW(EW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .exc_in(exc_in),
    .a(a), .b(b), .done(done), .exc_out(exc_out), .q(q)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic real pw(int n);
    return 2.0 ** real'(n);
  endfunction

  function automatic logic [FW-1:0] mk(logic s, int e, int f);
    return {s, EW'(e), F'(f)};
  endfunction

  task automatic chk(bit ok, string msg);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ready = 1'b0;
      exc_in = 1'b0;
    end
  endtask

  task automatic send(logic [FW-1:0] x, logic [FW-1:0] y, logic ei, string tag);
    item_t it;
    int ex, ey, ef;
    real r;
    @(negedge clk);
    a = x;
    b = y;
    exc_in = ei;
    ready = 1'b1;
    ex = int'(x[FW-2 -: EW]);
    ey = int'(y[FW-2 -: EW]);
    r = (1.0 + real'(x[F-1:0]) / pw(F)) / (1.0 + real'(y[F-1:0]) / pw(F));
    ef = ex - ey + BIAS - ((r < 1.0) ? 1 : 0);
    it.sgn = x[FW-1] ^ y[FW-1];
    it.zero = (ex == 0);
    it.exc = ei || (ey == 0) || (ex != 0 && (ef < 1 || ef > 2 ** EW - 2));
    it.val = r * pw(ex - ey);
    it.due = cyc + 3;
    it.tag = tag;
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 done with no pending request act=1 exp=0");
      end else begin
        item_t it;
        real av, rel;
        it = sb.pop_front();
        chk(cyc == it.due, $sformatf("R4 %s latency act=%0d exp=%0d", it.tag, cyc, it.due));
        chk(q[FW-1] == it.sgn, $sformatf("R2 %s sign act=%0b exp=%0b", it.tag, q[FW-1], it.sgn));
        chk(exc_out == it.exc,
            $sformatf("R5/R6/R8 %s exception act=%0b exp=%0b", it.tag, exc_out, it.exc));
        if (!it.exc && it.zero) begin
          chk(q[FW-2:0] == '0, $sformatf("R7 %s zero act=%h exp=0", it.tag, q[FW-2:0]));
        end else if (!it.exc) begin
          av = (1.0 + real'(q[F-1:0]) / pw(F)) * pw(int'(q[FW-2 -: EW]) - BIAS);
          rel = (av > it.val) ? (av - it.val) / it.val : (it.val - av) / it.val;
          chk(rel <= 4.0 / pw(F),
              $sformatf("R1 R3 %s value act=%g exp=%g (q=%h)", it.tag, av, it.val, q));
        end
      end
    end
  end

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && exc_out == 1'b0,
        $sformatf("R9 in reset act=%0b%0b exp=00", done, exc_out));
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0 && exc_out == 1'b0,
        $sformatf("R9 after reset act=%0b%0b exp=00", done, exc_out));

    send(mk(0, 127, 0), mk(0, 127, 0), 1'b0, "one_over_one");
    send(mk(0, 130, 2**F - 1), mk(0, 120, 0), 1'b0, "max_over_min");
    send(mk(0, 127, 0), mk(0, 127, 2**F - 1), 1'b0, "min_over_max");
    send(mk(1, 140, 12345), mk(0, 100, 12345), 1'b0, "equal_sig");
    send(mk(0, 127, 5000), mk(1, 127, 255), 1'b0, "yl_max_small_yh");
    send(mk(1, 127, 30000), mk(1, 127, 32767), 1'b0, "near_half");
    send(mk(0, 127, 7), mk(0, 127, 256 * 77), 1'b0, "yl_zero");
    idle(2);
    send(mk(0, 130, 100), mk(0, 125, 200), 1'b1, "exc_in");
    send(mk(0, 130, 100), mk(0, 0, 0), 1'b0, "div_by_zero");
    send(mk(1, 0, 0), mk(0, 0, 0), 1'b0, "zero_by_zero");
    send(mk(1, 0, 0), mk(0, 140, 3), 1'b0, "zero_dividend");
    send(mk(0, 0, 0), mk(1, 90, 999), 1'b0, "zero_dividend_neg");
    send(mk(0, 254, 0), mk(0, 1, 0), 1'b0, "overflow");
    send(mk(0, 1, 0), mk(0, 254, 0), 1'b0, "underflow");
    send(mk(0, 254, 2**F - 1), mk(0, 127, 0), 1'b0, "top_in_range");
    send(mk(0, 1, 0), mk(0, 127, 0), 1'b0, "bottom_in_range");
    idle(1);

    for (int i = 0; i < 300; i++) begin
      send(mk(1'($urandom % 2), 64 + int'($urandom % 120), int'($urandom % (2**F))),
           mk(1'($urandom % 2), 64 + int'($urandom % 120), int'($urandom % (2**F))),
           1'($urandom % 16 == 0), "random");
      if ($urandom % 4 == 0) idle(1 + int'($urandom % 3));
    end

    idle(8);
    chk(sb.size() == 0, $sformatf("R4 results missing act=%0d exp=0", sb.size()));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule